// File: doc/BRIEF.md
# Presettable Cascadable Binary Counter

A synchronous binary up-counter, four bits wide by default, whose state bits all change together on the rising clock edge. It can be preset in one cycle from a parallel data input, forced to zero by an active-low clear, or stepped by one. Counting needs two separate enables. The first, `en_p`, only gates the increment. The second, `en_t`, also qualifies the terminal-count output. This lets several counters be chained into a wider synchronous counter without extra gating: the `carry` of one stage drives `en_t` of the next stage, and one shared `en_p` stalls the whole chain.

A build-time parameter, `ASYNC_CLR`, sets how the clear acts. With it set, the clear acts at once, without a clock edge. With it cleared, the clear is sampled on the clock edge like any other control. The synchronous form lets an external decode of a chosen count feed the clear, which shortens the count cycle (for example to a decade counter).

Top module: `pcnt_top`

## Requirements
- R1: With `ASYNC_CLR`=1, driving `clr_n` low forces `q` to 0 at once, with no clock edge needed. `q` stays 0 across clock edges while `clr_n` is low, even when `load_n` is low and both enables are high.
- R2: With `ASYNC_CLR`=0, a low `clr_n` leaves `q` unchanged until the next rising edge. `q` is 0 after that edge, even when `load_n` is low and both enables are high (clear has priority over load).
- R3: With `clr_n` high and `load_n` low, `q` equals `din` after the next rising edge, whatever the enables are.
- R4: With `clr_n` and `load_n` high and both `en_p` and `en_t` high, `q` increases by one on each rising edge. It wraps from the all-ones value (15) to 0.
- R5: With `clr_n` and `load_n` high and either enable low, `q` keeps its value across rising edges.
- R6: `carry` is high exactly when `q` is all ones and `en_t` is high. It follows `en_t` with no clock edge, so it is never high while `en_t` is low.
- R7: Two sync-clear instances, with the low stage's `carry` driving the high stage's `en_t` and a shared `en_p`, form an 8-bit counter {high `q`, low `q`}. It counts 0..255 and wraps to 0, and it holds when the shared `en_p` is low.
- R8: A sync-clear instance whose `clr_n` is driven low while `q` equals 9 counts 0,1,...,9,0 (modulo 10).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Active-low clear; asynchronous or synchronous depending on `ASYNC_CLR` |
| load_n | input | 1 | Active-low synchronous parallel preset |
| en_p | input | 1 | Count enable that gates the increment only |
| en_t | input | 1 | Count enable that also qualifies `carry` |
| din | input | WIDTH | Preset data |
| q | output | WIDTH | Current count |
| carry | output | 1 | High while `q` is all ones and `en_t` is high |

## Verification
The timing of each result sets when the bench samples it:
- Load, count, hold and synchronous clear each show on `q` one rising edge after the inputs are applied. The bench drives inputs on the falling edge and samples one nanosecond after the following rising edge.
- The asynchronous clear and `carry` need no edge. The bench samples them a few nanoseconds after changing `clr_n` or `en_t`, with no rising edge in between.
- For the synchronous clear, the bench also samples `q` before the edge, to show that nothing has changed yet.

The cascade and decade runs compare `q` against a counter kept in the bench after every edge.

// File: rtl/pcnt_pkg.sv
package pcnt_pkg;
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_COUNT = 2'd1,
    OP_LOAD  = 2'd2,
    OP_CLEAR = 2'd3
  } pcnt_op_e;
endpackage

// File: rtl/pcnt_ctrl.sv
module pcnt_ctrl
  import pcnt_pkg::*;
#(
  parameter bit ASYNC_CLR = 1'b1
) (
  input  logic     clr_n,
  input  logic     load_n,
  input  logic     en_p,
  input  logic     en_t,
  output pcnt_op_e op
);
  logic sync_clr;

  generate
    if (ASYNC_CLR) begin : g_async
      // Clear acts on the register directly; it never shows up as an op here.
      assign sync_clr = 1'b0;
    end else begin : g_sync
      assign sync_clr = ~clr_n;
    end
  endgenerate

  // Priority: clear, load, count, hold
  always_comb begin
    if (sync_clr)            op = OP_CLEAR;
    else if (!load_n)        op = OP_LOAD;
    else if (en_p && en_t)   op = OP_COUNT;
    else                     op = OP_HOLD;
  end
endmodule

// File: rtl/pcnt_core.sv
module pcnt_core
  import pcnt_pkg::*;
#(
  parameter int WIDTH     = 4,
  parameter bit ASYNC_CLR = 1'b1
) (
  input  logic             clk,
  input  logic             clr_n,
  input  pcnt_op_e         op,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] q
);
  localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

  logic [WIDTH-1:0] q_nxt;
  logic             q_upd;

  always_comb begin
    q_nxt = q;
    q_upd = 1'b1;
    unique case (op)
      OP_CLEAR: q_nxt = '0;
      OP_LOAD:  q_nxt = din;
      OP_COUNT: q_nxt = q + ONE;
      default:  q_upd = 1'b0;
    endcase
  end

  generate
    if (ASYNC_CLR) begin : g_areg
      always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n)     q <= '0;
        else if (q_upd) q <= q_nxt;
      end

      AST_ASYNC_CLR_ZERO: assert property (@(posedge clk) !clr_n |-> (q == '0)); // R1
    end else begin : g_sreg
      always_ff @(posedge clk) begin
        if (q_upd) q <= q_nxt;
      end

      AST_SYNC_CLR_ZERO: assert property (@(posedge clk) disable iff (1'b0)
        !clr_n |=> (q == '0)); // R2
    end
  endgenerate

  AST_LOAD_TAKES_DIN: assert property (@(posedge clk) disable iff (ASYNC_CLR && !clr_n)
    (op == OP_LOAD) |=> (q == $past(din))); // R3
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (ASYNC_CLR && !clr_n)
    (op == OP_COUNT) |=> (q == $past(q) + ONE)); // R4
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (ASYNC_CLR && !clr_n)
    (op == OP_HOLD) |=> $stable(q)); // R5
endmodule

// File: rtl/pcnt_carry.sv
module pcnt_carry #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] q,
  input  logic             en_t,
  output logic             carry
);
  logic at_max;

  assign at_max = &q;
  assign carry  = at_max & en_t;
endmodule

// File: rtl/pcnt_top.sv
module pcnt_top
  import pcnt_pkg::*;
#(
  parameter int WIDTH     = 4,
  parameter bit ASYNC_CLR = 1'b1
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             load_n,
  input  logic             en_p,
  input  logic             en_t,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] q,
  output logic             carry
);
  pcnt_op_e op;

  pcnt_ctrl #(.ASYNC_CLR(ASYNC_CLR)) u_ctrl (
    .clr_n  (clr_n),
    .load_n (load_n),
    .en_p   (en_p),
    .en_t   (en_t),
    .op     (op)
  );

  pcnt_core #(.WIDTH(WIDTH), .ASYNC_CLR(ASYNC_CLR)) u_core (
    .clk   (clk),
    .clr_n (clr_n),
    .op    (op),
    .din   (din),
    .q     (q)
  );

  pcnt_carry #(.WIDTH(WIDTH)) u_carry (
    .q     (q),
    .en_t  (en_t),
    .carry (carry)
  );

  AST_CARRY_ONLY_AT_MAX: assert property (@(posedge clk) disable iff (ASYNC_CLR && !clr_n)
    carry |-> (q == '1)); // R6
  AST_CARRY_THEN_WRAP: assert property (@(posedge clk) disable iff (ASYNC_CLR && !clr_n)
    (carry && en_p && load_n && clr_n) |=> ((q == '0) && !carry)); // R4
endmodule

// File: tb/tb_pcnt_top.sv
`timescale 1ns/1ps
module tb_pcnt_top;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // shared controls for dut (async) and u_sync
  logic       a_clr_n = 1'b1, s_clr_n = 1'b1;
  logic       load_n = 1'b1, en_p = 1'b0, en_t = 1'b0;
  logic [3:0] din = 4'd0;
  logic [3:0] qa, qs;
  logic       ca, cs;

  pcnt_top #(.WIDTH(4), .ASYNC_CLR(1'b1)) dut (
    .clk(clk), .clr_n(a_clr_n), .load_n(load_n), .en_p(en_p), .en_t(en_t),
    .din(din), .q(qa), .carry(ca));

  pcnt_top #(.WIDTH(4), .ASYNC_CLR(1'b0)) u_sync (
    .clk(clk), .clr_n(s_clr_n), .load_n(load_n), .en_p(en_p), .en_t(en_t),
    .din(din), .q(qs), .carry(cs));

  // cascade
  logic       c_clr_n = 1'b1, c_en = 1'b0;
  logic [3:0] q_lo, q_hi;
  logic       c_lo, c_hi;

  pcnt_top #(.WIDTH(4), .ASYNC_CLR(1'b0)) u_lo (
    .clk(clk), .clr_n(c_clr_n), .load_n(1'b1), .en_p(c_en), .en_t(c_en),
    .din(4'd0), .q(q_lo), .carry(c_lo));

  pcnt_top #(.WIDTH(4), .ASYNC_CLR(1'b0)) u_hi (
    .clk(clk), .clr_n(c_clr_n), .load_n(1'b1), .en_p(c_en), .en_t(c_lo),
    .din(4'd0), .q(q_hi), .carry(c_hi));

  // decade
  logic       m_clr_n = 1'b1, m_en = 1'b0;
  logic [3:0] q_m;
  logic       c_m;
  logic       m_clr_eff;
  assign m_clr_eff = m_clr_n & ~(q_m == 4'd9);

  pcnt_top #(.WIDTH(4), .ASYNC_CLR(1'b0)) u_m10 (
    .clk(clk), .clr_n(m_clr_eff), .load_n(1'b1), .en_p(m_en), .en_t(m_en),
    .din(4'd0), .q(q_m), .carry(c_m));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic edge_step();
    @(posedge clk);
    #1;
  endtask

  task automatic t_async_clear();
    // preset then clear without an edge: R1
    @(negedge clk); load_n = 1'b0; din = 4'd10;
    edge_step();
    chk("R3 preset before clear", qa, 10);
    #0.5 a_clr_n = 1'b0;
    #0.5;
    chk("R1 async clear immediate", qa, 0);
    @(negedge clk); load_n = 1'b0; din = 4'd7; en_p = 1'b1; en_t = 1'b1;
    edge_step(); edge_step();
    chk("R1 clear held over load", qa, 0);
    @(negedge clk); a_clr_n = 1'b1; load_n = 1'b1; en_p = 1'b0; en_t = 1'b0;
    edge_step();
    chk("R1 released and holding", qa, 0);
  endtask

  task automatic t_sync_clear();
    @(negedge clk); load_n = 1'b0; din = 4'd5;
    edge_step();
    chk("R3 preset sync", qs, 5);
    @(negedge clk); s_clr_n = 1'b0; load_n = 1'b0; din = 4'd12; en_p = 1'b1; en_t = 1'b1;
    #1;
    chk("R2 no change before edge", qs, 5);
    edge_step();
    chk("R2 clear beats load", qs, 0);
    @(negedge clk); s_clr_n = 1'b1; load_n = 1'b1; en_p = 1'b0; en_t = 1'b0;
  endtask

  task automatic t_load_count_hold();
    @(negedge clk); load_n = 1'b0; din = 4'd12; en_p = 1'b0; en_t = 1'b0;
    edge_step();
    chk("R3 load with enables low", qa, 12);
    @(negedge clk); din = 4'd13; en_p = 1'b1; en_t = 1'b1;
    edge_step();
    chk("R3 load with enables high", qa, 13);
    @(negedge clk); load_n = 1'b1;
    edge_step();
    chk("R4 count 13->14", qa, 14);
    edge_step();
    chk("R4 count 14->15", qa, 15);
    chk("R6 carry at max with T", ca, 1);
    @(negedge clk); en_t = 1'b0;
    #1;
    chk("R6 carry drops with T", ca, 0);
    edge_step();
    chk("R5 hold T low", qa, 15);
    @(negedge clk); en_t = 1'b1; en_p = 1'b0;
    #1;
    chk("R6 carry back with T, P low", ca, 1);
    edge_step();
    chk("R5 hold P low", qa, 15);
    @(negedge clk); en_p = 1'b1;
    edge_step();
    chk("R4 wrap 15->0", qa, 0);
    chk("R6 carry low off max", ca, 0);
    @(negedge clk); en_p = 1'b0; en_t = 1'b0;
  endtask

  task automatic t_cascade();
    int exp;
    @(negedge clk); c_clr_n = 1'b0; c_en = 1'b1;
    edge_step();
    chk("R7 cascade cleared", {q_hi, q_lo}, 0);
    @(negedge clk); c_clr_n = 1'b1;
    exp = 0;
    for (int i = 0; i < 300; i++) begin
      edge_step();
      exp = (exp + 1) % 256;
      chk("R7 cascade count", {q_hi, q_lo}, exp);
    end
    @(negedge clk); c_en = 1'b0;
    edge_step(); edge_step();
    chk("R7 cascade hold", {q_hi, q_lo}, exp);
  endtask

  task automatic t_decade();
    @(negedge clk); m_clr_n = 1'b0; m_en = 1'b1;
    edge_step();
    chk("R8 decade cleared", q_m, 0);
    @(negedge clk); m_clr_n = 1'b1;
    for (int i = 1; i <= 25; i++) begin
      edge_step();
      chk("R8 decade count", q_m, i % 10);
    end
    @(negedge clk); m_en = 1'b0;
  endtask

  initial begin
    #800000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #1 a_clr_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R1 reset state", qa, 0);
    a_clr_n = 1'b1;
    t_async_clear();
    t_sync_clear();
    t_load_count_hold();
    t_cascade();
    t_decade();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule